// File: doc/BRIEF.md
# CAN Bit-Level Error Detector

This block watches the serial bit stream of a CAN node one bit at a time. On every sample strobe it gets the level the node drove, the level it read back from the bus, a code for the frame position supplied by the frame sequencer, the node's current role, and a marker for stuff bits. From these it raises the five CAN error indications: bit, stuff, form, CRC and acknowledgment.

The frame sequencer, the destuffer and the error counters sit outside the block. The sequencer owns the field code and the role and reacts to the error pulses. The CRC field arrives on the normal bus bit input while the field code reads "stuffed", so the remainder folds to zero on a clean frame.

The protocol's exceptions are built in. A dominant read-back while sending recessive is allowed in arbitration, in the acknowledge slot and during a passive error flag. A receiver that sees a dominant level in the last end-of-frame bit takes no form error.

Top module: `can_err_det`

## Requirements
- R1: A transmitter (`tx_role_i`=1) takes a bit error when `rx_bit_i` differs from `tx_bit_i` on a strobe. A receiver (`tx_role_i`=0) never takes a bit error. Level 1 is recessive and 0 is dominant.
- R2: Reading dominant while sending recessive is no bit error in field ARB (1), ACK_SLOT (4) or PEF (8). Reading recessive while sending dominant in ARB is a bit error.
- R3: A stuff error fires on the strobe that brings the sixth consecutive equal `rx_bit_i` level inside ARB or STUFFED (2). Stuff bits count toward the run. The run restarts at every level change and at `frame_start_i`. A seventh equal bit fires nothing new.
- R4: Strobes in any field other than ARB and STUFFED never raise a stuff error, and they clear the run.
- R5: A dominant `rx_bit_i` in CRC_DELIM (3), ACK_DELIM (5), EOF (6) or EOF_LAST (7) is a form error. A recessive level there is not.
- R6: In EOF_LAST a dominant level is no form error for a receiver, but it is one for a transmitter.
- R7: The CRC register uses polynomial 0x4599, 15 bits wide and shifted MSB first. It starts from zero at the `frame_start_i` bit and takes the non-stuff bits of ARB and STUFFED, with bits marked `stuff_bit_i` left out. A strobe in CRC_DELIM raises a CRC error when the register is non-zero.
- R8: A transmitter takes an acknowledgment error when it reads recessive in ACK_SLOT. A dominant read, or any read by a receiver, gives none.
- R9: Every error output is a one-cycle pulse registered on the clock edge that takes the strobe. Outputs are zero after reset and in any cycle that follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | Sample strobe, one per bit time |
| frame_start_i | input | 1 | Marks the start-of-frame bit (with strobe) |
| field_i | input | 4 | Frame position code (IDLE 0, ARB 1, STUFFED 2, CRC_DELIM 3, ACK_SLOT 4, ACK_DELIM 5, EOF 6, EOF_LAST 7, PEF 8) |
| tx_role_i | input | 1 | 1 = transmitter, 0 = receiver |
| tx_bit_i | input | 1 | Level driven by this node |
| rx_bit_i | input | 1 | Level sampled from the bus |
| stuff_bit_i | input | 1 | Current bit is a stuff bit |
| bit_err_o | output | 1 | Bit error pulse |
| stuff_err_o | output | 1 | Stuff error pulse |
| form_err_o | output | 1 | Form error pulse |
| crc_err_o | output | 1 | CRC error pulse |
| ack_err_o | output | 1 | Acknowledgment error pulse |

## Verification
A bit error and a stuff error can fall on the same bit. The case is a transmitter that drives five dominant bits and then a recessive sixth in the stuffed region while the bus stays dominant. The bench provokes it and expects both pulses in the one cycle after that strobe, and both outputs low in the cycle after. It also checks that the acknowledgment and bit indications stay apart in the ACK slot: a recessive read there is an acknowledgment error only, and a dominant read is neither.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int unsigned FIELD_W = 4;

  typedef enum logic [FIELD_W-1:0] {
    FLD_IDLE      = 4'd0,
    FLD_ARB       = 4'd1,
    FLD_STUFFED   = 4'd2,
    FLD_CRC_DELIM = 4'd3,
    FLD_ACK_SLOT  = 4'd4,
    FLD_ACK_DELIM = 4'd5,
    FLD_EOF       = 4'd6,
    FLD_EOF_LAST  = 4'd7,
    FLD_PEF       = 4'd8
  } field_e;

  localparam logic DOMINANT  = 1'b0;
  localparam logic RECESSIVE = 1'b1;
endpackage

// File: rtl/can_bit_mon.sv
module can_bit_mon
  import can_err_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_stb_i,
  input  field_e fld_i,
  input  logic   tx_role_i,
  input  logic   tx_bit_i,
  input  logic   rx_bit_i,
  output logic   bit_err_o,
  output logic   ack_err_o
);
  logic exempt_fld, overdriven, bit_err_d, ack_err_d;

  assign exempt_fld = (fld_i == FLD_ARB) || (fld_i == FLD_ACK_SLOT) || (fld_i == FLD_PEF);
  // recessive sent, dominant seen: tolerated in exempt fields
  assign overdriven = (tx_bit_i == RECESSIVE) && (rx_bit_i == DOMINANT);
  assign bit_err_d  = bit_stb_i && tx_role_i && (tx_bit_i != rx_bit_i) && !(exempt_fld && overdriven);
  assign ack_err_d  = bit_stb_i && tx_role_i && (fld_i == FLD_ACK_SLOT) && (rx_bit_i == RECESSIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_err_o <= 1'b0;
      ack_err_o <= 1'b0;
    end else begin
      bit_err_o <= bit_err_d;
      ack_err_o <= ack_err_d;
    end
  end

  // R1
  rx_no_bit_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !tx_role_i) |=> !bit_err_o);
  // R2
  exempt_overdrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && tx_role_i && tx_bit_i && !rx_bit_i &&
     (fld_i == FLD_ARB || fld_i == FLD_ACK_SLOT || fld_i == FLD_PEF)) |=> !bit_err_o);
  // R2
  arb_underdrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && tx_role_i && !tx_bit_i && rx_bit_i && fld_i == FLD_ARB) |=> bit_err_o);
  // R8
  ack_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && fld_i == FLD_ACK_SLOT && !rx_bit_i) |=> !ack_err_o);
endmodule

// File: rtl/can_stuff_mon.sv
module can_stuff_mon
  import can_err_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 6,
  localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 1)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_stb_i,
  input  logic   frame_start_i,
  input  field_e fld_i,
  input  logic   rx_bit_i,
  output logic   stuff_err_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(RUN_LIMIT - 1);

  logic [RUN_W-1:0] run_q;
  logic             last_q;
  logic             in_stuffed, continues;

  assign in_stuffed = (fld_i == FLD_ARB) || (fld_i == FLD_STUFFED);
  assign continues  = !frame_start_i && (run_q != '0) && (rx_bit_i == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      last_q      <= RECESSIVE;
      stuff_err_o <= 1'b0;
    end else begin
      stuff_err_o <= bit_stb_i && in_stuffed && continues && (run_q == RUN_PRE);
      if (bit_stb_i) begin
        last_q <= rx_bit_i;
        if (!in_stuffed)       run_q <= '0;
        else if (!continues)   run_q <= RUN_W'(1);
        else if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
      end
    end
  end

  // R3
  stuff_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |=> !stuff_err_o);
  // R4
  stuff_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !(fld_i == FLD_ARB || fld_i == FLD_STUFFED)) |=> !stuff_err_o);
  // R3
  stuff_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && frame_start_i) |=> !stuff_err_o);
endmodule

// File: rtl/can_form_mon.sv
module can_form_mon
  import can_err_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_stb_i,
  input  field_e fld_i,
  input  logic   tx_role_i,
  input  logic   rx_bit_i,
  output logic   form_err_o
);
  logic fixed_fld, rx_eof_waiver;

  always_comb begin
    unique case (fld_i)
      FLD_CRC_DELIM, FLD_ACK_DELIM, FLD_EOF, FLD_EOF_LAST: fixed_fld = 1'b1;
      default:                                             fixed_fld = 1'b0;
    endcase
  end

  // receiver tolerates dominant in final EOF bit (overload start)
  assign rx_eof_waiver = (fld_i == FLD_EOF_LAST) && !tx_role_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) form_err_o <= 1'b0;
    else         form_err_o <= bit_stb_i && fixed_fld && (rx_bit_i == DOMINANT) && !rx_eof_waiver;
  end

  // R5
  delim_dominant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && (fld_i == FLD_CRC_DELIM || fld_i == FLD_ACK_DELIM) && !rx_bit_i) |=> form_err_o);
  // R5
  fixed_recessive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && rx_bit_i) |=> !form_err_o);
  // R6
  eof_last_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && fld_i == FLD_EOF_LAST && !tx_role_i) |=> !form_err_o);
endmodule

// File: rtl/can_crc_chk.sv
module can_crc_chk
  import can_err_pkg::*;
#(
  parameter int unsigned        CRC_W    = 15,
  parameter logic [CRC_W-1:0]   CRC_POLY = 15'h4599
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_stb_i,
  input  logic   frame_start_i,
  input  field_e fld_i,
  input  logic   stuff_bit_i,
  input  logic   rx_bit_i,
  output logic   crc_err_o
);
  logic [CRC_W-1:0] crc_q, crc_base, crc_next;
  logic             covered, fb;

  assign covered  = (fld_i == FLD_ARB) || (fld_i == FLD_STUFFED);
  assign crc_base = frame_start_i ? '0 : crc_q;
  assign fb       = rx_bit_i ^ crc_base[CRC_W-1];
  assign crc_next = {crc_base[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q     <= '0;
      crc_err_o <= 1'b0;
    end else begin
      crc_err_o <= bit_stb_i && (fld_i == FLD_CRC_DELIM) && (crc_q != '0);
      if (bit_stb_i && covered && !stuff_bit_i) crc_q <= crc_next;
    end
  end

  // R7
  crc_at_delim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> $past(bit_stb_i && fld_i == FLD_CRC_DELIM));
  // R7
  crc_stuff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && stuff_bit_i && !frame_start_i) |=> $stable(crc_q));
endmodule

// File: rtl/can_err_det.sv
module can_err_det
  import can_err_pkg::*;
#(
  parameter int unsigned      RUN_LIMIT = 6,
  parameter int unsigned      CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY  = 15'h4599
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_stb_i,
  input  logic         frame_start_i,
  input  logic [3:0]   field_i,
  input  logic         tx_role_i,
  input  logic         tx_bit_i,
  input  logic         rx_bit_i,
  input  logic         stuff_bit_i,
  output logic         bit_err_o,
  output logic         stuff_err_o,
  output logic         form_err_o,
  output logic         crc_err_o,
  output logic         ack_err_o
);
  field_e fld;
  assign fld = field_e'(field_i);

  can_bit_mon u_bit (
    .clk_i, .rst_ni, .bit_stb_i, .fld_i(fld), .tx_role_i,
    .tx_bit_i, .rx_bit_i, .bit_err_o, .ack_err_o
  );

  can_stuff_mon #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
    .clk_i, .rst_ni, .bit_stb_i, .frame_start_i, .fld_i(fld),
    .rx_bit_i, .stuff_err_o
  );

  can_form_mon u_form (
    .clk_i, .rst_ni, .bit_stb_i, .fld_i(fld), .tx_role_i,
    .rx_bit_i, .form_err_o
  );

  can_crc_chk #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni, .bit_stb_i, .frame_start_i, .fld_i(fld),
    .stuff_bit_i, .rx_bit_i, .crc_err_o
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> !(bit_err_o || stuff_err_o || form_err_o || crc_err_o || ack_err_o));
endmodule

// File: tb/can_err_det_test.sv
module can_err_det_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] F_IDLE = 4'd0, F_ARB = 4'd1, F_STF = 4'd2, F_CRCD = 4'd3,
                         F_ACKS = 4'd4, F_ACKD = 4'd5, F_EOF = 4'd6, F_EOFL = 4'd7, F_PEF = 4'd8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_stb = 0, frame_start = 0, tx_role = 0, tx_bit = 1, rx_bit = 1, stuff_bit = 0;
  logic [3:0] field = F_IDLE;
  logic bit_err, stuff_err, form_err, crc_err, ack_err;
  logic s_bit, s_stuff, s_form, s_crc, s_ack;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_det uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(bit_stb), .frame_start_i(frame_start),
    .field_i(field), .tx_role_i(tx_role), .tx_bit_i(tx_bit), .rx_bit_i(rx_bit),
    .stuff_bit_i(stuff_bit), .bit_err_o(bit_err), .stuff_err_o(stuff_err),
    .form_err_o(form_err), .crc_err_o(crc_err), .ack_err_o(ack_err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one strobe; outputs captured at the following falling edge
  task automatic send(input logic [3:0] f, input logic role, input logic tb, input logic rb,
                      input logic sb = 1'b0, input logic fs = 1'b0);
    @(negedge clk);
    field = f; tx_role = role; tx_bit = tb; rx_bit = rb; stuff_bit = sb; frame_start = fs;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0; frame_start = 1'b0; stuff_bit = 1'b0;
    s_bit = bit_err; s_stuff = stuff_err; s_form = form_err; s_crc = crc_err; s_ack = ack_err;
  endtask

  function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
    logic nx = b ^ c[14];
    logic [14:0] r = {c[13:0], 1'b0};
    return nx ? (r ^ 15'h4599) : r;
  endfunction

  task automatic t_reset;
    chk("R9 reset", bit_err | stuff_err | form_err | crc_err | ack_err, 1'b0);
  endtask

  task automatic t_bit;
    send(F_STF, 1, 1, 0); chk("R1 tx rec->dom", s_bit, 1);
    send(F_STF, 1, 0, 1); chk("R1 tx dom->rec", s_bit, 1);
    send(F_STF, 0, 1, 0); chk("R1 receiver", s_bit, 0);
    send(F_STF, 1, 1, 1); chk("R1 match", s_bit, 0);
  endtask

  task automatic t_exempt;
    send(F_ARB, 1, 1, 0);  chk("R2 arb lost", s_bit, 0);
    send(F_ACKS, 1, 1, 0); chk("R2 ack slot bit", s_bit, 0);
    chk("R8 ack seen", s_ack, 0);
    send(F_PEF, 1, 1, 0);  chk("R2 passive flag", s_bit, 0);
    send(F_ARB, 1, 0, 1);  chk("R2 arb recessive read", s_bit, 1);
  endtask

  task automatic t_stuff;
    send(F_ARB, 0, 0, 0, 0, 1); chk("R3 run1", s_stuff, 0);
    for (int i = 2; i <= 5; i++) begin
      send(F_ARB, 0, 0, 0); chk("R3 run<6", s_stuff, 0);
    end
    send(F_ARB, 0, 0, 0); chk("R3 sixth", s_stuff, 1);
    send(F_ARB, 0, 0, 0); chk("R3 seventh", s_stuff, 0);
    for (int i = 1; i <= 5; i++) send(F_STF, 0, 1, 1);
    chk("R3 restart after change", s_stuff, 0);
    send(F_STF, 0, 0, 0, 1); chk("R3 stuff bit breaks run", s_stuff, 0);
    for (int i = 1; i <= 4; i++) send(F_ARB, 0, 0, 0);
    send(F_ARB, 0, 0, 0, 0, 1); chk("R3 frame start clears", s_stuff, 0);
    for (int i = 2; i <= 5; i++) send(F_ARB, 0, 0, 0);
    chk("R3 five after restart", s_stuff, 0);
  endtask

  task automatic t_outside;
    int hits = 0;
    for (int i = 1; i <= 7; i++) begin
      send(F_EOF, 0, 1, 1); hits += s_stuff;
    end
    for (int i = 1; i <= 7; i++) begin
      send(F_IDLE, 0, 0, 0); hits += s_stuff;
    end
    chk("R4 no stuff outside", hits != 0, 0);
  endtask

  task automatic t_form;
    send(F_CRCD, 0, 1, 0); chk("R5 crc delim", s_form, 1);
    send(F_ACKD, 0, 1, 0); chk("R5 ack delim", s_form, 1);
    send(F_EOF, 0, 1, 0);  chk("R5 eof", s_form, 1);
    send(F_ACKD, 0, 1, 1); chk("R5 recessive ok", s_form, 0);
    send(F_EOFL, 0, 1, 0); chk("R6 rx eof last", s_form, 0);
    send(F_EOFL, 1, 1, 0); chk("R6 tx eof last", s_form, 1);
  endtask

  task automatic t_crc(input logic corrupt);
    logic [19:0] msg = 20'h2B4D6;
    logic [14:0] c = '0;
    for (int i = 19; i >= 0; i--) c = crc_step(c, msg[i]);
    for (int i = 19; i >= 0; i--) begin
      send(i >= 8 ? F_ARB : F_STF, 0, 1, msg[i], 0, i == 19);
      if (i == 15) send(F_ARB, 0, 1, 1, 1);
    end
    for (int i = 14; i >= 0; i--) send(F_STF, 0, 1, (i == 0 && corrupt) ? ~c[i] : c[i]);
    send(F_CRCD, 0, 1, 1);
    chk(corrupt ? "R7 bad crc" : "R7 good crc", s_crc, corrupt);
  endtask

  task automatic t_ack;
    send(F_ACKS, 1, 1, 1); chk("R8 no ack", s_ack, 1);
    chk("R8 no bit err", s_bit, 0);
    send(F_ACKS, 0, 1, 1); chk("R8 receiver", s_ack, 0);
  endtask

  task automatic t_overlap;
    send(F_ARB, 1, 0, 0, 0, 1);
    for (int i = 2; i <= 5; i++) send(F_STF, 1, 0, 0);
    send(F_STF, 1, 1, 0);
    chk("R1 overlap bit", s_bit, 1);
    chk("R3 overlap stuff", s_stuff, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", bit_err | stuff_err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bit();
    t_exempt();
    t_stuff();
    t_outside();
    t_form();
    t_crc(1'b0);
    t_crc(1'b1);
    t_ack();
    t_overlap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule